// File: doc/BRIEF.md
# Backplane SRAM Slave Controller

This block lets a 16-bit SRAM array answer cycles on an asynchronous backplane bus whose 22 address/data lines are shared between an address phase and a data phase. When the master raises its sync strobe, the controller captures the address and the I/O-page flag. It then waits for the master's data-in (read) or data-out (write) strobe. While the strobe is held, it drives SRAM output or write enable plus per-bank, per-byte chip enables. After a fixed number of system-clock cycles it raises the reply handshake. All bus strobes are resynchronised to the system clock through two flops before use.

Each access resolves to one of four bank pairs. Address bits 21 and 20 pick the bank, bits 19..1 form the word address, and bit 0 selects the byte for byte writes. A cycle is ignored completely when the I/O-page flag was latched set. It is also ignored when the latched address lies below a lower bound that is configured in 64 KB units, which lets the card share the address space with memory that sits on a CPU board.

The state machine has four named states:
- `ST_IDLE`: no sync.
- `ST_HELD`: address latched, no strobe being served.
- `ST_SETTLE`: enables are on and the reply delay is counting.
- `ST_REPLY`: reply is asserted.

The transitions are:
- capture (`ST_IDLE`→`ST_HELD` on sync).
- start (`ST_HELD`→`ST_SETTLE` on a strobe when the cycle is selected).
- settle-done (`ST_SETTLE`→`ST_REPLY` after the delay).
- release (`ST_SETTLE`/`ST_REPLY`→`ST_HELD` when the strobe drops).
- abandon (any state→`ST_IDLE` when sync drops or bus initialise is seen).

Returning from release to `ST_HELD` while sync stays high is what allows a read-modify-write.

Top module: `bpmem_slave`

## Requirements
- R1: The address on `bus_dal` is captured into the latch as sync is recognised. The latch holds it through the data phase, for reads and writes alike. `ram_addr` presents latched bits 19..1.
- R2: When the I/O-page flag was latched set, no chip enable, write enable, output enable or reply is produced.
- R3: Latched bits 21..20 (value k) select bank k. Only bit k of `ram_ce_lo`/`ram_ce_hi` may be set, and at most one bank is ever enabled.
- R4: On a write with `bus_bytewr`=0, both `ram_ce_lo[k]` and `ram_ce_hi[k]` are set. With `bus_bytewr`=1 and latched bit 0 = 0, only `ram_ce_lo[k]` is set. With `bus_bytewr`=1 and bit 0 = 1, only `ram_ce_hi[k]` is set.
- R5: A read always enables both bytes of the selected bank, whatever the value of `bus_bytewr`.
- R6: The data-out strobe produces `ram_we` and the data-in strobe produces `ram_oe`; the two are never both set. During a read, `bus_rdata_oe`=1 and `bus_rdata` carries `ram_rdata`. `ram_wdata` carries `bus_dal[15:0]`.
- R7: `bus_reply` rises exactly REPLY_DLY clock cycles after `ram_we` or `ram_oe` rises. With the two-flop synchroniser, this is 3+REPLY_DLY rising edges after the strobe input rises.
- R8: After the master drops its strobe, `bus_reply`, `ram_we`/`ram_oe` and the chip enables fall on the third rising edge.
- R9: With sync held, a read followed by a write reaches the same latched address (read-modify-write).
- R10: `bus_init` clears the address latch to zero. Dropping sync leaves the latch unchanged.
- R11: A cycle whose latched bits 21..16 are below `low_bound` gets no enables and no reply. A `low_bound` of 0 disables this inhibit.
- R12: After reset, all enables, `bus_reply` and `bus_rdata_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_init | input | 1 | Bus initialise, clears latch and state |
| bus_sync | input | 1 | Asynchronous sync strobe from the master |
| bus_din | input | 1 | Asynchronous data-in (read) strobe |
| bus_dout | input | 1 | Asynchronous data-out (write) strobe |
| bus_bytewr | input | 1 | Byte-write flag for writes |
| bus_iopage | input | 1 | I/O-page flag during the address phase |
| bus_dal | input | 22 | Multiplexed address/data lines (data on 15..0) |
| low_bound | input | 6 | Lower bound in 64 KB units, 0 = off |
| bus_rdata | output | 16 | Read data toward the bus |
| bus_rdata_oe | output | 1 | Data direction: 1 = card drives bus |
| bus_reply | output | 1 | Reply handshake |
| ram_addr | output | 19 | Word address to the SRAM |
| ram_ce_lo | output | 4 | Low-byte chip enable per bank |
| ram_ce_hi | output | 4 | High-byte chip enable per bank |
| ram_we | output | 1 | SRAM write enable |
| ram_oe | output | 1 | SRAM output enable |
| ram_wdata | output | 16 | Write data to the SRAM |
| ram_rdata | input | 16 | Read data from the SRAM |

## Verification
Every bus input is changed on a falling clock edge. The latch therefore captures on the third rising edge after sync rises, so the address is held for four cycles before the data lines are reused. Enables appear three edges after a strobe, reply appears 3+REPLY_DLY (6) edges after it, and everything drops three edges after the strobe is released. Each check counts falling-edge samples from the stimulus and compares against these counts exactly. Blocked cycles (I/O page, lower bound) are watched for twelve cycles with the strobe held and are then confirmed by reading the untouched word back through a normal cycle.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_REPLY  = 2'd3
    } bus_state_t;
endpackage

// File: rtl/bpm_sync.sv
module bpm_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/bpm_addr_latch.sv
module bpm_addr_latch #(
    parameter int ADDR_W   = 22,
    parameter int GRAN_LSB = 16,
    localparam int BOUND_W = ADDR_W - GRAN_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cap,
    input  logic [ADDR_W-1:0]  dal,
    input  logic               iop_in,
    input  logic [BOUND_W-1:0] bound,
    output logic [ADDR_W-1:0]  addr_q,
    output logic               iop_q,
    output logic               sel
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q <= '0;
            iop_q  <= 1'b0;
        end else if (cap) begin
            addr_q <= dal;
            iop_q  <= iop_in;
        end
    end

    // the window starts at bound * 64 KB; bound 0 lets everything through
    assign sel = !iop_q && (addr_q[ADDR_W-1:GRAN_LSB] >= bound);

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> $stable(addr_q));
endmodule

// File: rtl/bpm_bank_dec.sv
module bpm_bank_dec #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic [BANK_W-1:0] bank,
    input  logic              a0,
    input  logic              active,
    input  logic              op_wr,
    input  logic              bw_q,
    output logic [NBANK-1:0]  ce_lo,
    output logic [NBANK-1:0]  ce_hi
);
    logic lo_en, hi_en;

    // reads and full-word writes take both halves; a byte write takes one
    assign lo_en = !op_wr || !bw_q || !a0;
    assign hi_en = !op_wr || !bw_q ||  a0;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign ce_lo[b] = active && (bank == BANK_W'(b)) && lo_en;
        assign ce_hi[b] = active && (bank == BANK_W'(b)) && hi_en;
    end
endmodule

// File: rtl/bpm_fsm.sv
module bpm_fsm
    import bpm_pkg::*;
#(
    parameter int REPLY_DLY = 3,
    localparam int CNT_W = (REPLY_DLY < 2) ? 1 : $clog2(REPLY_DLY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sync_s,
    input  logic din_s,
    input  logic dout_s,
    input  logic sel,
    input  logic bytewr_in,
    output logic cap,
    output logic active,
    output logic op_wr,
    output logic bw_q,
    output logic reply
);
    bus_state_t state, nxt;
    logic [CNT_W-1:0] cnt;
    logic stb;

    assign stb = op_wr ? dout_s : din_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (sync_s) nxt = ST_HELD;
            ST_HELD:   if (!sync_s) nxt = ST_IDLE;
                       else if (sel && (din_s || dout_s)) nxt = ST_SETTLE;
            ST_SETTLE: if (!sync_s) nxt = ST_IDLE;
                       else if (!stb) nxt = ST_HELD;
                       else if (cnt == CNT_W'(REPLY_DLY - 1)) nxt = ST_REPLY;
            ST_REPLY:  if (!sync_s) nxt = ST_IDLE;
                       else if (!stb) nxt = ST_HELD;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ST_IDLE;
            cnt   <= '0;
            op_wr <= 1'b0;
            bw_q  <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_SETTLE) ? cnt + 1'b1 : '0;
            if (state == ST_HELD && nxt == ST_SETTLE) begin
                op_wr <= dout_s;
                bw_q  <= bytewr_in;
            end
        end
    end

    always_comb begin
        cap    = (state == ST_IDLE) && sync_s;
        active = (state == ST_SETTLE) || (state == ST_REPLY);
        reply  = (state == ST_REPLY);
    end

    // R7
    reply_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reply) |-> $past(active));

    // R8
    reply_drops_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (reply && !stb) |=> !reply);
endmodule

// File: rtl/bpmem_slave.sv
module bpmem_slave #(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int GRAN_LSB  = 16,
    parameter int REPLY_DLY = 3,
    localparam int NBANK    = 1 << BANK_W,
    localparam int WADDR_W  = ADDR_W - BANK_W - 1,
    localparam int BOUND_W  = ADDR_W - GRAN_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_init,
    input  logic               bus_sync,
    input  logic               bus_din,
    input  logic               bus_dout,
    input  logic               bus_bytewr,
    input  logic               bus_iopage,
    input  logic [ADDR_W-1:0]  bus_dal,
    input  logic [BOUND_W-1:0] low_bound,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rdata_oe,
    output logic               bus_reply,
    output logic [WADDR_W-1:0] ram_addr,
    output logic [NBANK-1:0]   ram_ce_lo,
    output logic [NBANK-1:0]   ram_ce_hi,
    output logic               ram_we,
    output logic               ram_oe,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata
);
    logic [2:0]        strobes_s;
    logic              sync_s, din_s, dout_s;
    logic [ADDR_W-1:0] addr_q;
    logic              iop_q, sel, cap, active, op_wr, bw_q;

    bpm_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_sync, bus_din, bus_dout}),
        .d_sync  (strobes_s)
    );
    assign {sync_s, din_s, dout_s} = strobes_s;

    bpm_addr_latch #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (bus_init),
        .cap    (cap),
        .dal    (bus_dal),
        .iop_in (bus_iopage),
        .bound  (low_bound),
        .addr_q (addr_q),
        .iop_q  (iop_q),
        .sel    (sel)
    );

    bpm_fsm #(.REPLY_DLY(REPLY_DLY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bus_init),
        .sync_s    (sync_s),
        .din_s     (din_s),
        .dout_s    (dout_s),
        .sel       (sel),
        .bytewr_in (bus_bytewr),
        .cap       (cap),
        .active    (active),
        .op_wr     (op_wr),
        .bw_q      (bw_q),
        .reply     (bus_reply)
    );

    bpm_bank_dec #(.BANK_W(BANK_W)) u_dec (
        .bank   (addr_q[ADDR_W-1 -: BANK_W]),
        .a0     (addr_q[0]),
        .active (active),
        .op_wr  (op_wr),
        .bw_q   (bw_q),
        .ce_lo  (ram_ce_lo),
        .ce_hi  (ram_ce_hi)
    );

    assign ram_addr     = addr_q[WADDR_W:1];
    assign ram_we       = active && op_wr;
    assign ram_oe       = active && !op_wr;
    assign ram_wdata    = bus_dal[DATA_W-1:0];
    assign bus_rdata_oe = ram_oe;
    assign bus_rdata    = ram_oe ? ram_rdata : '0;

    // R2
    iopage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iop_q |-> (ram_ce_lo == '0 && ram_ce_hi == '0 && !ram_we && !ram_oe && !bus_reply));

    // R3
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_ce_lo | ram_ce_hi));

    // R5
    read_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_oe |-> (ram_ce_lo == ram_ce_hi && ram_ce_lo != '0));

    // R6
    we_oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_oe));
endmodule

// File: tb/sim_bpmem_slave.sv
module sim_bpmem_slave;
    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_init = 1'b0, bus_sync = 1'b0, bus_din = 1'b0, bus_dout = 1'b0;
    logic        bus_bytewr = 1'b0, bus_iopage = 1'b0;
    logic [21:0] bus_dal = '0;
    logic [5:0]  low_bound = '0;
    logic [15:0] bus_rdata, ram_wdata, ram_rdata;
    logic        bus_rdata_oe, bus_reply, ram_we, ram_oe;
    logic [18:0] ram_addr;
    logic [3:0]  ram_ce_lo, ram_ce_hi;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    bpmem_slave #(.REPLY_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .bus_sync(bus_sync),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_bytewr(bus_bytewr),
        .bus_iopage(bus_iopage), .bus_dal(bus_dal), .low_bound(low_bound),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_reply(bus_reply),
        .ram_addr(ram_addr), .ram_ce_lo(ram_ce_lo), .ram_ce_hi(ram_ce_hi),
        .ram_we(ram_we), .ram_oe(ram_oe), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural SRAM: 4 banks x 64 words (word address bits 5..0)
    logic [15:0] mem [256];

    always @(posedge clk) begin
        if (ram_we) begin
            for (int b = 0; b < 4; b++) begin
                if (ram_ce_lo[b]) mem[{b[1:0], ram_addr[5:0]}][7:0]  <= ram_wdata[7:0];
                if (ram_ce_hi[b]) mem[{b[1:0], ram_addr[5:0]}][15:8] <= ram_wdata[15:8];
            end
        end
    end

    always_comb begin
        ram_rdata = '0;
        for (int b = 0; b < 4; b++)
            if (ram_oe && ram_ce_lo[b] && ram_ce_hi[b])
                ram_rdata = mem[{b[1:0], ram_addr[5:0]}];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [21:0] a, input bit iop);
        @(negedge clk);
        bus_dal = a;
        bus_iopage = iop;
        bus_sync = 1'b1;
        repeat (4) @(negedge clk);
        bus_iopage = 1'b0;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        bus_sync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_level(input bit lvl, output int n);
        n = 0;
        while (bus_reply != lvl && n < 30) begin
            @(negedge clk);
            n++;
        end
    endtask

    // write with full checks on timing, enables and latched address
    task automatic do_write(input logic [21:0] a, input logic [15:0] d, input bit bw,
                            input logic [3:0] exp_lo, input logic [3:0] exp_hi,
                            input string tag);
        int n;
        addr_phase(a, 1'b0);
        bus_dal = {6'h2A, d};
        chk(ram_addr == a[19:1], {"R1 latched addr ", tag}, 32'(ram_addr), 32'(a[19:1]));
        bus_bytewr = bw;
        @(negedge clk);
        bus_dout = 1'b1;
        wait_level(1'b1, n);
        chk(n == 3 + DLY, {"R7 reply delay ", tag}, n, 3 + DLY);
        chk(ram_ce_lo == exp_lo && ram_ce_hi == exp_hi, {"R3/R4 enables ", tag},
            {ram_ce_hi, ram_ce_lo}, {exp_hi, exp_lo});
        chk(ram_we && !ram_oe && ram_wdata == d, {"R6 write path ", tag},
            {ram_we, ram_oe, ram_wdata}, {2'b10, d});
        bus_dout = 1'b0;
        wait_level(1'b0, n);
        chk(n == 3 && !ram_we && ram_ce_lo == 0, {"R8 release ", tag}, n, 3);
        bus_bytewr = 1'b0;
        end_cycle();
    endtask

    task automatic do_read(input logic [21:0] a, input bit bw, output logic [15:0] d);
        int n;
        logic [3:0] m;
        m = 4'b1 << a[21:20];
        addr_phase(a, 1'b0);
        bus_dal = '0;
        bus_bytewr = bw;
        @(negedge clk);
        bus_din = 1'b1;
        wait_level(1'b1, n);
        chk(n == 3 + DLY, "R7 read reply delay", n, 3 + DLY);
        chk(ram_ce_lo == m && ram_ce_hi == m, "R5 read enables both bytes",
            {ram_ce_hi, ram_ce_lo}, {m, m});
        chk(bus_rdata_oe && ram_oe && !ram_we, "R6 read direction",
            {bus_rdata_oe, ram_oe, ram_we}, 3'b110);
        d = bus_rdata;
        bus_din = 1'b0;
        wait_level(1'b0, n);
        bus_bytewr = 1'b0;
        end_cycle();
    endtask

    task automatic do_blocked(input logic [21:0] a, input bit iop, input string tag);
        bit quiet = 1'b1;
        addr_phase(a, iop);
        bus_dal = 22'h0005A5;
        @(negedge clk);
        bus_dout = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (bus_reply || ram_we || ram_oe || ram_ce_lo != 0 || ram_ce_hi != 0) quiet = 1'b0;
        end
        chk(quiet, tag, {bus_reply, ram_we, ram_ce_hi, ram_ce_lo}, 0);
        bus_dout = 1'b0;
        end_cycle();
    endtask

    task automatic t_reset();
        chk(!bus_reply && !ram_we && !ram_oe && !bus_rdata_oe && ram_ce_lo == 0 && ram_ce_hi == 0,
            "R12 reset outputs", {bus_reply, ram_we, ram_oe, bus_rdata_oe, ram_ce_hi, ram_ce_lo}, 0);
    endtask

    task automatic t_banks();
        logic [15:0] d;
        for (int b = 0; b < 4; b++)
            do_write({b[1:0], 19'(8 + b), 1'b0}, 16'hC000 + 16'(b), 1'b0,
                     4'b1 << b, 4'b1 << b, "bank write");
        for (int b = 0; b < 4; b++) begin
            do_read({b[1:0], 19'(8 + b), 1'b0}, 1'b0, d);
            chk(d == 16'hC000 + 16'(b), "R3 bank readback", d, 16'hC000 + 16'(b));
        end
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        do_write(22'h100040, 16'hAAAA, 1'b0, 4'b0010, 4'b0010, "R4 word");
        do_write(22'h100040, 16'h0055, 1'b1, 4'b0010, 4'b0000, "R4 low byte");
        do_write(22'h100041, 16'h6600, 1'b1, 4'b0000, 4'b0010, "R4 high byte");
        do_read(22'h100040, 1'b1, d);
        chk(d == 16'h6655, "R4/R5 byte merge, read ignores bytewr", d, 16'h6655);
    endtask

    task automatic t_iopage();
        logic [15:0] d;
        do_write(22'h000102, 16'h1234, 1'b0, 4'b0001, 4'b0001, "R7 basic");
        do_blocked(22'h000102, 1'b1, "R2 io page silent");
        do_read(22'h000102, 1'b0, d);
        chk(d == 16'h1234, "R2 io page left memory alone", d, 16'h1234);
    endtask

    task automatic t_bound();
        logic [15:0] d;
        do_write(22'h01FFFE, 16'h1111, 1'b0, 4'b0001, 4'b0001, "R11 preload");
        @(negedge clk);
        low_bound = 6'd2;
        do_blocked(22'h01FFFE, 1'b0, "R11 below bound silent");
        do_write(22'h020000, 16'hBEEF, 1'b0, 4'b0001, 4'b0001, "R11 at bound");
        @(negedge clk);
        low_bound = 6'd0;
        do_read(22'h01FFFE, 1'b0, d);
        chk(d == 16'h1111, "R11 blocked write had no effect", d, 16'h1111);
        do_read(22'h020000, 1'b0, d);
        chk(d == 16'hBEEF, "R11 write at bound stored", d, 16'hBEEF);
    endtask

    task automatic t_rmw();
        int n;
        logic [15:0] d, d2;
        do_write(22'h300040, 16'h0F0F, 1'b0, 4'b1000, 4'b1000, "R9 preload");
        addr_phase(22'h300040, 1'b0);
        bus_dal = '0;
        bus_din = 1'b1;
        wait_level(1'b1, n);
        d = bus_rdata;
        chk(d == 16'h0F0F, "R9 rmw read", d, 16'h0F0F);
        bus_din = 1'b0;
        wait_level(1'b0, n);
        bus_dal = {6'h0, d + 16'h1};
        @(negedge clk);
        bus_dout = 1'b1;
        wait_level(1'b1, n);
        chk(n == 3 + DLY && ram_we && ram_ce_lo == 4'b1000 && ram_addr == 19'h20,
            "R9 rmw write phase", {n[7:0], 3'b0, ram_we, ram_ce_lo, ram_addr},
            {8'(3 + DLY), 3'b0, 1'b1, 4'b1000, 19'h20});
        bus_dout = 1'b0;
        wait_level(1'b0, n);
        end_cycle();
        do_read(22'h300040, 1'b0, d2);
        chk(d2 == 16'h0F10, "R9 rmw result", d2, 16'h0F10);
    endtask

    task automatic t_init();
        addr_phase(22'h3FFFFE, 1'b0);
        end_cycle();
        chk(ram_addr == 19'h7FFFF, "R10 latch kept after sync drop", ram_addr, 19'h7FFFF);
        @(negedge clk);
        bus_init = 1'b1;
        @(negedge clk);
        bus_init = 1'b0;
        chk(ram_addr == 19'h0, "R10 init clears latch", ram_addr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_iopage();
        t_banks();
        t_bytes();
        t_bound();
        t_rmw();
        t_init();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule